// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo PCM audio from a three-wire serial port: a bit clock, a frame clock and a data line. It acts as a slave on those clocks. A faster system clock oversamples all three lines. A 3-bit format code selects one of eight framings:

- right-justified at 16, 20 or 24 bits;
- I2S at 16, 20 or 24 bits;
- 16-bit left-justified;
- a 16-bit DSP frame that starts with a short sync pulse.

Every frame is 64 bit clocks long. For each complete stereo frame the block presents a 24-bit left sample and a 24-bit right sample with a one-cycle valid strobe. Each sample is aligned at the MSB, and the low bits are zero when the word is shorter than 24 bits.

In the three non-DSP framings, a half-frame is accepted only when exactly 32 bits arrived between two frame-clock transitions. A stereo pair is released only when a left half and the right half after it were both accepted. A change of the format code throws away any frame in progress, and the receiver locks again on the frame clock that follows.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted, `valid` is low and both `left` and `right` are zero.
- R2: Format codes 0, 1 and 2 select right-justified framing of 16, 20 and 24 bits. The word is the last N data bits of a half-frame, MSB first, sampled on rising bit-clock edges. The left half is the one where the frame clock is high.
- R3: Format codes 3, 4 and 5 select I2S framing of 16, 20 and 24 bits. The MSB is the second bit after a frame-clock transition, sampled on rising edges. The left half is the one where the frame clock is low.
- R4: Format code 6 selects 16-bit left-justified framing. The MSB is the first bit after a frame-clock transition, sampled on rising edges. The left half is the one where the frame clock is high.
- R5: Format code 7 selects the DSP frame, sampled on falling bit-clock edges. The frame clock is high for one bit as a sync. The next 16 bits are the left word and the 16 bits after that are the right word, both MSB first. The last 31 bits of the frame are ignored.
- R6: Bits outside the data word of a half-frame have no effect on the samples, whatever their value.
- R7: `valid` is high for exactly one system-clock cycle per completed stereo frame. `left` and `right` change only in a cycle where `valid` is high.
- R8: A change of the format code discards the frame in progress, and no sample from that frame is ever output. The cycle after a change never carries `valid`. Reception resumes with the next full frame in the new format.
- R9: In the non-DSP framings, a half-frame with other than 32 bits is rejected together with its stereo pair.
- R10: A word shorter than 24 bits appears in bits 23 down to 24-N of the output, and the bits below it are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk | input | 1 | Serial bit clock |
| fclk | input | 1 | Serial frame clock or DSP sync |
| sdat | input | 1 | Serial data |
| fmt | input | 3 | Format code, 0 to 7 |
| left | output | 24 | Left sample, aligned at the MSB |
| right | output | 24 | Right sample, aligned at the MSB |
| valid | output | 1 | One-cycle strobe for a new stereo pair |

## Verification
The assertions assume that each bit-clock phase lasts several system-clock cycles. They also assume that the format code holds steady from the start of a frame until its pair is strobed. Only then does the zero fill in the low bits follow from the format code seen on the port.

The stimulus meets both assumptions:
- it holds each bit-clock phase for four system cycles;
- it changes the format only while the bit clock is idle, by a short detour through another code.

Data is changed to a decoy value just after the non-sampling edge and settles to the real bit before the sampling edge. Sampling on the wrong edge would therefore pick up the decoy.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int SYNC  = 2,
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  input  logic             fclk,
  input  logic             sdat,
  input  logic [2:0]       fmt,
  output logic [OUT_W-1:0] left,
  output logic [OUT_W-1:0] right,
  output logic             valid
);
  localparam int HALF = 32;
  localparam int CW   = 6;

  logic [SYNC:0]      bclk_p;
  logic [SYNC-1:0]    fclk_p, sdat_p;
  logic [HALF-1:0]    sh;
  logic [CW-1:0]      cnt;
  logic               lr_q, armed, have_l;
  logic [2:0]         fmt_q;
  logic [OUT_W-1:0]   lbuf, w;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bclk_p <= '0;
      fclk_p <= '0;
      sdat_p <= '0;
    end else begin
      bclk_p <= {bclk_p[SYNC-1:0], bclk};
      fclk_p <= {fclk_p[SYNC-2:0], fclk};
      sdat_p <= {sdat_p[SYNC-2:0], sdat};
    end

  wire b_now = bclk_p[SYNC-1];
  wire b_old = bclk_p[SYNC];
  wire fs    = fclk_p[SYNC-1];
  wire ds    = sdat_p[SYNC-1];

  wire dsp     = (fmt == 3'd7);
  wire i2s     = (fmt == 3'd3) || (fmt == 3'd4) || (fmt == 3'd5);
  wire smp     = dsp ? (b_old & ~b_now) : (~b_old & b_now);
  wire fmt_chg = (fmt != fmt_q);
  wire edge_lr = (fs != lr_q);
  wire full    = (cnt == CW'(HALF));
  wire half_l  = i2s ? ~lr_q : lr_q;
  wire [HALF-1:0] shn = {sh[HALF-2:0], ds};
  wire [CW-1:0]   cnt_inc = (cnt == {CW{1'b1}}) ? cnt : cnt + CW'(1);

  always_comb
    case (fmt)
      3'd0:    w = {sh[15:0], 8'b0};
      3'd1:    w = {sh[19:0], 4'b0};
      3'd2:    w = sh[23:0];
      3'd3:    w = {sh[30:15], 8'b0};
      3'd4:    w = {sh[30:11], 4'b0};
      3'd5:    w = sh[30:7];
      3'd6:    w = {sh[31:16], 8'b0};
      default: w = {shn[31:16], 8'b0};
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fmt_q  <= '0;
      sh     <= '0;
      cnt    <= '0;
      lr_q   <= 1'b0;
      armed  <= 1'b0;
      have_l <= 1'b0;
      lbuf   <= '0;
      left   <= '0;
      right  <= '0;
      valid  <= 1'b0;
    end else begin
      valid <= 1'b0;
      fmt_q <= fmt;
      if (fmt_chg) begin
        cnt    <= '0;
        armed  <= 1'b0;
        have_l <= 1'b0;
      end else if (smp) begin
        sh   <= shn;
        lr_q <= fs;
        if (dsp) begin
          if (fs && !lr_q) begin
            cnt   <= '0;
            armed <= 1'b1;
          end else begin
            cnt <= cnt_inc;
            if (armed && cnt == CW'(HALF-1)) begin
              left  <= w;
              right <= {shn[15:0], 8'b0};
              valid <= 1'b1;
              armed <= 1'b0;
            end
          end
        end else if (edge_lr) begin
          cnt <= CW'(1);
          if (!full) begin
            have_l <= 1'b0;
          end else if (half_l) begin
            lbuf   <= w;
            have_l <= 1'b1;
          end else begin
            have_l <= 1'b0;
            if (have_l) begin
              left  <= lbuf;
              right <= w;
              valid <= 1'b1;
            end
          end
        end else begin
          cnt <= cnt_inc;
        end
      end
    end
endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  fmt,
  input logic [23:0] left,
  input logic [23:0] right,
  input logic        valid
);
  always @(negedge clk)
    if (!rst_n)
      p_rst_clear_r1: assert (!valid && left == 24'd0 && right == 24'd0);

  p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (left == $past(left) && right == $past(right)));

  p_fill16_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (fmt == 3'd0 || fmt == 3'd3 || fmt == 3'd6 || fmt == 3'd7))
      |-> (left[7:0] == 8'd0 && right[7:0] == 8'd0));

  p_fill20_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (fmt == 3'd1 || fmt == 3'd4))
      |-> (left[3:0] == 4'd0 && right[3:0] == 4'd0));

  p_drop_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt != $past(fmt)) |=> !valid);
endmodule

bind serial_audio_rx serial_audio_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fmt(fmt),
  .left(left), .right(right), .valid(valid)
);

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b0, fclk = 1'b0, sdat = 1'b0;
  logic [2:0] fmt = 3'd0;
  logic [23:0] left, right;
  logic valid;

  int n_run = 0, n_fail = 0, got_n = 0, dbl = 0, total = 0;
  logic [23:0] got_l [0:7];
  logic [23:0] got_r [0:7];
  logic prev_v = 1'b0;

  always #2.5 clk = ~clk;

  serial_audio_rx u_dut (.clk(clk), .rst_n(rst_n), .bclk(bclk), .fclk(fclk),
    .sdat(sdat), .fmt(fmt), .left(left), .right(right), .valid(valid));

  localparam logic [50:0] VEC [0:9] = '{
    {3'd0, 24'h12ABCD, 24'h345678},
    {3'd1, 24'hF8001F, 24'h0C3A5E},
    {3'd2, 24'h800001, 24'h7FFFFE},
    {3'd3, 24'h00FFFF, 24'hA55A5A},
    {3'd4, 24'h9ABCDE, 24'h13579B},
    {3'd5, 24'hFEDCBA, 24'h012345},
    {3'd6, 24'h00C001, 24'h008000},
    {3'd7, 24'h00BEEF, 24'h001234},
    {3'd2, 24'h000000, 24'hFFFFFF},
    {3'd5, 24'h5A5A5A, 24'hC3C3C3}
  };

  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (got_n < 8) begin
        got_l[got_n] = left;
        got_r[got_n] = right;
      end
      got_n++;
      total++;
      if (prev_v) dbl++;
    end
    prev_v = valid;
  end

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int wid(input logic [2:0] m);
    case (m)
      3'd1, 3'd4: return 20;
      3'd2, 3'd5: return 24;
      default:    return 16;
    endcase
  endfunction

  function automatic logic [23:0] expv(input logic [2:0] m, input logic [23:0] v);
    int n = wid(m);
    logic [23:0] mask = 24'hFFFFFF >> (24 - n);
    return (v & mask) << (24 - n);
  endfunction

  function automatic logic bitv(input logic [2:0] m, input int p, input logic [23:0] v, input logic junk);
    int n = wid(m);
    if (m <= 3'd2) begin
      if (p >= 32 - n) return v[31-p];
    end else if (m <= 3'd5) begin
      if (p >= 1 && p <= n) return v[n-p];
    end else if (p < 16) return v[15-p];
    return junk;
  endfunction

  function automatic string rtag(input logic [2:0] m);
    if (m <= 3'd2) return "R2";
    if (m <= 3'd5) return "R3";
    if (m == 3'd6) return "R4";
    return "R5";
  endfunction

  task automatic send_bit(input logic fc, input logic d);
    if (fmt == 3'd7) begin
      bclk = 1'b1; fclk = fc; sdat = ~d;
      repeat (2) @(posedge clk);
      sdat = d;
      repeat (2) @(posedge clk);
      bclk = 1'b0;
      repeat (4) @(posedge clk);
    end else begin
      bclk = 1'b0; fclk = fc; sdat = ~d;
      repeat (2) @(posedge clk);
      sdat = d;
      repeat (2) @(posedge clk);
      bclk = 1'b1;
      repeat (4) @(posedge clk);
    end
  endtask

  function automatic logic first_lvl(input logic [2:0] m);
    return (m >= 3'd3 && m <= 3'd5) ? 1'b0 : 1'b1;
  endfunction

  task automatic send_frame(input logic [2:0] m, input logic [23:0] l, input logic [23:0] r, input logic junk);
    if (m == 3'd7) begin
      for (int p = 0; p < 64; p++)
        send_bit(p == 0, (p >= 1 && p <= 16) ? l[16-p] :
                         (p >= 17 && p <= 32) ? r[32-p] : junk);
    end else begin
      for (int p = 0; p < 32; p++) send_bit(first_lvl(m), bitv(m, p, l, junk));
      for (int p = 0; p < 32; p++) send_bit(~first_lvl(m), bitv(m, p, r, junk));
    end
  endtask

  task automatic start_mode(input logic [2:0] m);
    fmt = m ^ 3'd1;
    repeat (3) @(posedge clk);
    fmt = m;
    repeat (3) @(posedge clk);
    if (m == 3'd7) for (int p = 0; p < 4; p++) send_bit(1'b0, 1'b0);
    got_n = 0;
  endtask

  task automatic finish_test(input logic [2:0] m);
    if (m != 3'd7) send_bit(first_lvl(m), 1'b0);
    repeat (8) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int exp_total;
    exp_total = 0;
    repeat (5) @(posedge clk);
    #1;
    chk(!valid && left == 0 && right == 0, "R1 reset outputs", {left, right}, 48'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < 10; i++) begin
      logic [2:0]  m;
      logic [23:0] l, r;
      logic        junk;
      string       t;
      {m, l, r} = VEC[i];
      junk = i[0];
      t = junk ? {rtag(m), "/R6/R10"} : {rtag(m), "/R10"};
      start_mode(m);
      send_frame(m, l, r, junk);
      send_frame(m, r, l, junk);
      finish_test(m);
      exp_total += 2;
      chk(got_n == 2, {t, " pair count"}, 48'(got_n), 48'd2);
      if (got_n == 2) begin
        chk(got_l[0] == expv(m, l) && got_r[0] == expv(m, r), {t, " frame 0"},
            {got_l[0], got_r[0]}, {expv(m, l), expv(m, r)});
        chk(got_l[1] == expv(m, r) && got_r[1] == expv(m, l), {t, " frame 1"},
            {got_l[1], got_r[1]}, {expv(m, r), expv(m, l)});
      end
    end

    // R8: change format mid frame, partial frame dropped
    start_mode(3'd0);
    for (int p = 0; p < 32; p++) send_bit(1'b1, bitv(3'd0, p, 24'h00AAAA, 1'b0));
    for (int p = 0; p < 10; p++) send_bit(1'b0, 1'b1);
    fmt = 3'd2;
    repeat (4) @(posedge clk);
    got_n = 0;
    send_frame(3'd2, 24'h654321, 24'h0FEDCB, 1'b0);
    finish_test(3'd2);
    exp_total += 1;
    chk(got_n == 1, "R8 count after change", 48'(got_n), 48'd1);
    chk(got_l[0] == 24'h654321 && got_r[0] == 24'h0FEDCB, "R8 resumed frame",
        {got_l[0], got_r[0]}, {24'h654321, 24'h0FEDCB});

    // R9: 31-bit left half rejects its pair
    start_mode(3'd1);
    for (int p = 1; p < 32; p++) send_bit(1'b1, bitv(3'd1, p, 24'h0ABCDE, 1'b0));
    for (int p = 0; p < 32; p++) send_bit(1'b0, bitv(3'd1, p, 24'h011111, 1'b0));
    send_frame(3'd1, 24'h0F0F0F, 24'h0A0A0A, 1'b0);
    finish_test(3'd1);
    exp_total += 1;
    chk(got_n == 1, "R9 short half rejected", 48'(got_n), 48'd1);
    chk(got_l[0] == 24'hF0F0F0 && got_r[0] == 24'hA0A0A0, "R9 next frame",
        {got_l[0], got_r[0]}, {24'hF0F0F0, 24'hA0A0A0});

    chk(dbl == 0, "R7 strobe longer than one cycle", 48'(dbl), 48'd0);
    chk(total == exp_total, "R7 strobe count", 48'(total), 48'(exp_total));

    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(!valid && left == 0 && right == 0, "R1 reset clears outputs", {left, right}, 48'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule